// File: doc/BRIEF.md
# Dual Accumulator Saturation Status Unit

This block keeps two signed accumulators, A and B, each made of a 64-bit body with 8 guard bits on top (72 bits in all). On each cycle one accumulator may take an add or a subtract of a 72-bit operand. Each accumulator has a static saturation enable and a static mode select. The mode picks the 64-bit body range or the full 72-bit range as the clamping boundary. The result is registered and visible on the cycle after the operation.

Beside the datapath the block keeps six status flags in one field. Each accumulator has a guard-spill flag, refreshed on every operation to that accumulator, and a sticky saturation flag. Two further bits report the OR of each pair. Software may write the flags through a strobed port, and its write wins over a hardware update in the same cycle. A one-cycle arithmetic-error trap request is raised when a flag goes from clear to set while its trap enable is on. A saturation flag qualifies only while its accumulator runs without saturation, because in that case the flag means the sign has been lost.

Top module: `dacc_status_unit`

## Requirements
- R1: When `op_valid` is high, the accumulator picked by `op_sel` (0 = A, 1 = B) takes `acc + operand` (`op_sub` = 0) or `acc - operand` (`op_sub` = 1) in two's complement, and the result appears on the cycle after; the other accumulator and an idle accumulator keep their values.
- R2: On every operation to an accumulator, its guard flag is rewritten: it is set when bits 71 down to 63 of the new stored value are not all equal, and cleared otherwise; the other accumulator's guard flag is untouched.
- R3: A result that leaves the 64-bit range but stays within 72 bits is stored in full when saturation is off or the 72-bit mode is selected.
- R4: With saturation on and the 64-bit mode (mode input 0), a result outside the 64-bit range is clamped to 0x00_7FFF_FFFF_FFFF_FFFF or 0xFF_8000_0000_0000_0000, following the sign of the exact sum, and the saturation flag is set.
- R5: With saturation on and the 72-bit mode (mode input 1), a result outside the 72-bit range is clamped to 0x7F_FFFF_FFFF_FFFF_FFFF or 0x80_0000_0000_0000_0000, and the saturation flag is set.
- R6: With saturation off, a 72-bit overflow stores the wrapped value and sets the saturation flag.
- R7: A saturation flag stays set after later in-range operations until software clears it.
- R8: `status` is ordered, MSB to LSB: guard A, guard B, saturation A, saturation B, guard A OR guard B, saturation A OR saturation B.
- R9: Writing 0 to bit 1 of `status` clears both guard flags, and writing 0 to bit 0 clears both saturation flags. Writing 1 to either combined bit has no effect.
- R10: A write with `sw_wr_en` loads each individual flag whose strobe bit is set from the matching data bit, and it takes priority over a hardware update in the same cycle.
- R11: `trap_req` pulses for one cycle when guard A (with `trap_en_ovf_a`) or guard B (with `trap_en_ovf_b`) goes from clear to set, in the same cycle as the flag becomes visible.
- R12: With `trap_en_cat` set, a saturation flag going from clear to set raises the same pulse, but only if that accumulator's saturation enable is off.
- R13: Reset clears both accumulators, all six flags and `trap_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Perform an operation this cycle |
| op_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| op_sub | input | 1 | 1 = subtract operand, 0 = add |
| op_operand | input | 72 | Signed operand |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_mode_a | input | 1 | A boundary: 0 = 64-bit, 1 = 72-bit |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_mode_b | input | 1 | B boundary: 0 = 64-bit, 1 = 72-bit |
| sw_wr_en | input | 1 | Software flag write |
| sw_wr_strobe | input | 6 | Per-bit write strobe, same order as `status` |
| sw_wr_data | input | 6 | Write data, same order as `status` |
| trap_en_ovf_a | input | 1 | Trap on guard A rise |
| trap_en_ovf_b | input | 1 | Trap on guard B rise |
| trap_en_cat | input | 1 | Trap on saturation-flag rise while unsaturated |
| acc_a | output | 72 | Accumulator A |
| acc_b | output | 72 | Accumulator B |
| status | output | 6 | Flag field |
| trap_req | output | 1 | One-cycle arithmetic-error trap request |

## Verification
The hardest case to reach is the catastrophic trap. It needs a saturation flag that is clear while the accumulator already sits at the edge of the 72-bit range, with saturation turned off for that accumulator only. Flags are sticky and the accumulator only moves by arithmetic, so the stimulus first drives A to the positive 72-bit clamp with saturation on. It then clears the saturation flag by a strobed write, drops the enable and adds one. The same path also shows that the rise with saturation enabled gives no pulse, and that a software clear beats a same-cycle clamp.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

   typedef enum logic {
      SAT_BODY = 1'b0,
      SAT_FULL = 1'b1
   } sat_mode_e;

   localparam int N_ACC  = 2;
   localparam int FLAG_W = 6;

   // flag field positions, MSB to LSB
   localparam int F_GA  = 5;
   localparam int F_GB  = 4;
   localparam int F_SA  = 3;
   localparam int F_SB  = 2;
   localparam int F_GOR = 1;
   localparam int F_SOR = 0;

endpackage

// File: rtl/dacc_addsub.sv
module dacc_addsub #(
   parameter int W         = 72,
   parameter bit USE_CARRY = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         ovf
);

   if (W < 2) begin : g_bad_w
      $error("dacc_addsub: W must be at least 2");
   end

   logic [W-1:0] b_eff;
   assign b_eff = sub ? ~b : b;

   if (USE_CARRY) begin : g_carry
      logic [W-1:0] low;
      logic         c_in;
      logic         c_out;
      assign low   = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, sub};
      assign c_in  = low[W-1];
      assign c_out = (a[W-1] & b_eff[W-1]) | (a[W-1] & c_in) | (b_eff[W-1] & c_in);
      assign sum   = {a[W-1] ^ b_eff[W-1] ^ c_in, low[W-2:0]};
      assign ovf   = c_in ^ c_out;
   end else begin : g_ext
      logic [W:0] ext;
      assign ext = {a[W-1], a} + {b_eff[W-1], b_eff} + {{W{1'b0}}, sub};
      assign sum = ext[W-1:0];
      assign ovf = ext[W] ^ ext[W-1];
   end

endmodule

// File: rtl/dacc_lane.sv
module dacc_lane
   import dacc_pkg::*;
#(
   parameter int BODY_W    = 64,
   parameter int GUARD_W   = 8,
   parameter bit USE_CARRY = 1'b1,
   localparam int ACC_W    = BODY_W + GUARD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             sub,
   input  logic [ACC_W-1:0] operand,
   input  logic             sat_en,
   input  logic             sat_mode,
   output logic [ACC_W-1:0] acc,
   output logic             guard_next,
   output logic             sat_evt
);

   localparam int SPAN = GUARD_W + 1;
   localparam logic [ACC_W-1:0] FULL_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] FULL_MIN = {1'b1, {(ACC_W-1){1'b0}}};
   localparam logic [ACC_W-1:0] BODY_MAX = {{SPAN{1'b0}}, {(BODY_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] BODY_MIN = {{SPAN{1'b1}}, {(BODY_W-1){1'b0}}};

   if (BODY_W < 2 || GUARD_W < 1) begin : g_bad_cfg
      $error("dacc_lane: BODY_W >= 2 and GUARD_W >= 1 required");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] raw;
   logic             full_ovf;
   logic             true_neg;
   logic             body_ovf;
   logic             exceed;
   logic [ACC_W-1:0] clamp_val;
   logic [ACC_W-1:0] next_val;
   logic [SPAN-1:0]  raw_top;
   logic [SPAN-1:0]  nxt_top;
   sat_mode_e        mode;

   assign mode = sat_mode_e'(sat_mode);

   dacc_addsub #(
      .W         (ACC_W),
      .USE_CARRY (USE_CARRY)
   ) i_addsub (
      .a   (acc_q),
      .b   (operand),
      .sub (sub),
      .sum (raw),
      .ovf (full_ovf)
   );

   // exact sign of the unbounded result
   assign true_neg = full_ovf ? ~raw[ACC_W-1] : raw[ACC_W-1];
   assign raw_top  = raw[ACC_W-1:BODY_W-1];
   assign body_ovf = full_ovf || !((raw_top == '0) || (raw_top == '1));

   always_comb begin
      if (sat_en && mode == SAT_BODY) exceed = body_ovf;
      else                             exceed = full_ovf;
   end

   always_comb begin
      if (mode == SAT_FULL) clamp_val = true_neg ? FULL_MIN : FULL_MAX;
      else                  clamp_val = true_neg ? BODY_MIN : BODY_MAX;
   end

   assign next_val   = (sat_en && exceed) ? clamp_val : raw;
   assign nxt_top    = next_val[ACC_W-1:BODY_W-1];
   assign guard_next = !((nxt_top == '0) || (nxt_top == '1));
   assign sat_evt    = fire && exceed;

   always_ff @(posedge clk) begin
      if (!rst_n)    acc_q <= '0;
      else if (fire) acc_q <= next_val;
   end

   assign acc = acc_q;

   AST_BODY_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sat_en && mode == SAT_BODY) |=>
         ((acc_q[ACC_W-1:BODY_W-1] == '0) || (acc_q[ACC_W-1:BODY_W-1] == '1))); // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(acc_q)); // R1

endmodule

// File: rtl/dacc_flags.sv
module dacc_flags
   import dacc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_ACC-1:0]  upd,
   input  logic [N_ACC-1:0]  guard_next,
   input  logic [N_ACC-1:0]  sat_evt,
   input  logic [N_ACC-1:0]  sat_en,
   input  logic              sw_wr_en,
   input  logic [FLAG_W-1:0] sw_strobe,
   input  logic [FLAG_W-1:0] sw_data,
   input  logic [N_ACC-1:0]  trap_en_ovf,
   input  logic              trap_en_cat,
   output logic [FLAG_W-1:0] status,
   output logic              trap_req
);

   logic [N_ACC-1:0] gq, gn;
   logic [N_ACC-1:0] sq, sn;
   logic [N_ACC-1:0] lane_trap;
   logic             clr_g_all;
   logic             clr_s_all;
   logic             trap_q;

   assign clr_g_all = sw_wr_en && sw_strobe[F_GOR] && !sw_data[F_GOR];
   assign clr_s_all = sw_wr_en && sw_strobe[F_SOR] && !sw_data[F_SOR];

   for (genvar i = 0; i < N_ACC; i++) begin : g_acc
      localparam int G_IDX = F_GA - i;
      localparam int S_IDX = F_SA - i;

      always_comb begin
         gn[i] = upd[i] ? guard_next[i] : gq[i];
         if (sw_wr_en && sw_strobe[G_IDX]) gn[i] = sw_data[G_IDX];
         if (clr_g_all)                    gn[i] = 1'b0;
      end

      always_comb begin
         sn[i] = sq[i] | sat_evt[i];
         if (sw_wr_en && sw_strobe[S_IDX]) sn[i] = sw_data[S_IDX];
         if (clr_s_all)                    sn[i] = 1'b0;
      end

      assign lane_trap[i] = (gn[i] & ~gq[i] & trap_en_ovf[i])
                          | (sn[i] & ~sq[i] & trap_en_cat & ~sat_en[i]);

      AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!upd[i] && !(sw_wr_en && (sw_strobe[G_IDX] || sw_strobe[F_GOR])))
            |=> $stable(gq[i])); // R2

      AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (sq[i] && !(sw_wr_en && (sw_strobe[S_IDX] || sw_strobe[F_SOR])))
            |=> sq[i]); // R7
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gq     <= '0;
         sq     <= '0;
         trap_q <= 1'b0;
      end else begin
         gq     <= gn;
         sq     <= sn;
         trap_q <= |lane_trap;
      end
   end

   assign status[F_GA]  = gq[0];
   assign status[F_GB]  = gq[1];
   assign status[F_SA]  = sq[0];
   assign status[F_SB]  = sq[1];
   assign status[F_GOR] = |gq;
   assign status[F_SOR] = |sq;
   assign trap_req      = trap_q;

   AST_TRAP_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_q |-> ($rose(gq[0]) || $rose(gq[1]) || $rose(sq[0]) || $rose(sq[1]))); // R11

endmodule

// File: rtl/dacc_status_unit.sv
module dacc_status_unit
   import dacc_pkg::*;
#(
   parameter int BODY_W    = 64,
   parameter int GUARD_W   = 8,
   parameter bit USE_CARRY = 1'b1,
   localparam int ACC_W    = BODY_W + GUARD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic             op_sel,
   input  logic             op_sub,
   input  logic [ACC_W-1:0] op_operand,
   input  logic             sat_en_a,
   input  logic             sat_mode_a,
   input  logic             sat_en_b,
   input  logic             sat_mode_b,
   input  logic             sw_wr_en,
   input  logic [5:0]       sw_wr_strobe,
   input  logic [5:0]       sw_wr_data,
   input  logic             trap_en_ovf_a,
   input  logic             trap_en_ovf_b,
   input  logic             trap_en_cat,
   output logic [ACC_W-1:0] acc_a,
   output logic [ACC_W-1:0] acc_b,
   output logic [5:0]       status,
   output logic             trap_req
);

   if (FLAG_W != 6 || N_ACC != 2) begin : g_bad_pkg
      $error("dacc_status_unit: package layout mismatch");
   end

   logic [N_ACC-1:0] fire;
   logic [N_ACC-1:0] sat_en_v;
   logic [N_ACC-1:0] sat_mode_v;
   logic [N_ACC-1:0] guard_next;
   logic [N_ACC-1:0] sat_evt;
   logic [ACC_W-1:0] acc_v [N_ACC];

   assign sat_en_v   = {sat_en_b, sat_en_a};
   assign sat_mode_v = {sat_mode_b, sat_mode_a};

   for (genvar i = 0; i < N_ACC; i++) begin : g_lane
      assign fire[i] = op_valid && (op_sel == 1'(i));

      dacc_lane #(
         .BODY_W    (BODY_W),
         .GUARD_W   (GUARD_W),
         .USE_CARRY (USE_CARRY)
      ) i_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .fire       (fire[i]),
         .sub        (op_sub),
         .operand    (op_operand),
         .sat_en     (sat_en_v[i]),
         .sat_mode   (sat_mode_v[i]),
         .acc        (acc_v[i]),
         .guard_next (guard_next[i]),
         .sat_evt    (sat_evt[i])
      );
   end

   dacc_flags i_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd         (fire),
      .guard_next  (guard_next),
      .sat_evt     (sat_evt),
      .sat_en      (sat_en_v),
      .sw_wr_en    (sw_wr_en),
      .sw_strobe   (sw_wr_strobe),
      .sw_data     (sw_wr_data),
      .trap_en_ovf ({trap_en_ovf_b, trap_en_ovf_a}),
      .trap_en_cat (trap_en_cat),
      .status      (status),
      .trap_req    (trap_req)
   );

   assign acc_a = acc_v[0];
   assign acc_b = acc_v[1];

   AST_ONE_LANE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fire)); // R1

endmodule

// File: tb/test_dacc_status_unit.sv
module test_dacc_status_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0, op_sel = 1'b0, op_sub = 1'b0;
   logic [71:0] op_operand = '0;
   logic        sat_en_a = 1'b0, sat_mode_a = 1'b0, sat_en_b = 1'b0, sat_mode_b = 1'b0;
   logic        sw_wr_en = 1'b0;
   logic [5:0]  sw_wr_strobe = '0, sw_wr_data = '0;
   logic        trap_en_ovf_a = 1'b0, trap_en_ovf_b = 1'b0, trap_en_cat = 1'b0;
   logic [71:0] acc_a, acc_b;
   logic [5:0]  status;
   logic        trap_req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   dacc_status_unit i_dacc_status_unit (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .op_sub(op_sub),
      .op_operand(op_operand), .sat_en_a(sat_en_a), .sat_mode_a(sat_mode_a),
      .sat_en_b(sat_en_b), .sat_mode_b(sat_mode_b), .sw_wr_en(sw_wr_en),
      .sw_wr_strobe(sw_wr_strobe), .sw_wr_data(sw_wr_data),
      .trap_en_ovf_a(trap_en_ovf_a), .trap_en_ovf_b(trap_en_ovf_b),
      .trap_en_cat(trap_en_cat), .acc_a(acc_a), .acc_b(acc_b),
      .status(status), .trap_req(trap_req)
   );

   // {sel, sub, sat_en, mode, operand, expected acc, expected status}
   typedef logic [153:0] vec_t;
   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      {4'b0000, 72'h000000000000000005, 72'h000000000000000005, 6'h00}, // R1 add
      {4'b0100, 72'h000000000000000008, 72'hFFFFFFFFFFFFFFFFFD, 6'h00}, // R1 sub
      {4'b1000, 72'h007FFFFFFFFFFFFFFF, 72'h007FFFFFFFFFFFFFFF, 6'h00}, // R8
      {4'b1011, 72'h000000000000000001, 72'h008000000000000000, 6'h12}, // R3 R2
      {4'b0000, 72'h000000000000000001, 72'hFFFFFFFFFFFFFFFFFE, 6'h12}, // R2 other lane
      {4'b1110, 72'h000000000000000001, 72'h007FFFFFFFFFFFFFFF, 6'h00}, // R2 refresh
      {4'b1010, 72'h000000000000000001, 72'h007FFFFFFFFFFFFFFF, 6'h05}, // R4 clamp
      {4'b1000, 72'h000000000000000005, 72'h008000000000000004, 6'h17}, // R7 R3
      {4'b0011, 72'h800000000000000000, 72'h800000000000000000, 6'h3F}, // R5 min
      {4'b0011, 72'h7FFFFFFFFFFFFFFFFF, 72'hFFFFFFFFFFFFFFFFFF, 6'h1F}, // R2 R7
      {4'b0011, 72'h7FFFFFFFFFFFFFFFFF, 72'h7FFFFFFFFFFFFFFFFE, 6'h3F}, // R8
      {4'b0011, 72'h7FFFFFFFFFFFFFFFFF, 72'h7FFFFFFFFFFFFFFFFF, 6'h3F}  // R5 max
   };

   task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(input bit ov, input bit sel, input bit sub, input logic [71:0] opd,
                       input bit swe, input logic [5:0] stb, input logic [5:0] dat);
      @(negedge clk);
      op_valid = ov; op_sel = sel; op_sub = sub; op_operand = opd;
      sw_wr_en = swe; sw_wr_strobe = stb; sw_wr_data = dat;
      @(negedge clk);
      op_valid = 1'b0; sw_wr_en = 1'b0; sw_wr_strobe = '0; sw_wr_data = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state
      chk("R13 acc_a", acc_a, '0);
      chk("R13 acc_b", acc_b, '0);
      chk("R13 status", 72'(status), '0);
      chk("R13 trap", 72'(trap_req), '0);

      for (int k = 0; k < NV; k++) begin
         if (VEC[k][153]) begin sat_en_b = VEC[k][151]; sat_mode_b = VEC[k][150]; end
         else             begin sat_en_a = VEC[k][151]; sat_mode_a = VEC[k][150]; end
         step(1'b1, VEC[k][153], VEC[k][152], VEC[k][149:78], 1'b0, '0, '0);
         chk($sformatf("R1 vec%0d acc", k), VEC[k][153] ? acc_b : acc_a, VEC[k][77:6]);
         chk($sformatf("R8 vec%0d status", k), 72'(status), 72'(VEC[k][5:0]));
      end

      // R9 combined clears
      step(1'b0, 1'b0, 1'b0, '0, 1'b1, 6'b000010, 6'b000000);
      chk("R9 clear guard pair", 72'(status), 72'h0D);
      step(1'b0, 1'b0, 1'b0, '0, 1'b1, 6'b000010, 6'b000010);
      chk("R9 write one ignored", 72'(status), 72'h0D);
      step(1'b0, 1'b0, 1'b0, '0, 1'b1, 6'b000001, 6'b000000);
      chk("R9 clear sat pair", 72'(status), 72'h00);
      // R10 software set
      step(1'b0, 1'b0, 1'b0, '0, 1'b1, 6'b001000, 6'b001000);
      chk("R10 sw set SA", 72'(status), 72'h09);
      // R10 priority: clear SA while A saturates (72-bit mode)
      sat_en_a = 1'b1; sat_mode_a = 1'b1;
      step(1'b1, 1'b0, 1'b0, 72'h1, 1'b1, 6'b001000, 6'b000000);
      chk("R10 sw beats hw", 72'(status), 72'h22);
      chk("R5 clamp held", acc_a, 72'h7FFFFFFFFFFFFFFFFF);

      // R11 guard trap
      trap_en_ovf_a = 1'b1;
      step(1'b0, 1'b0, 1'b0, '0, 1'b1, 6'b100000, 6'b000000);
      chk("R11 no trap on clear", 72'(trap_req), 72'h0);
      chk("R10 sw clear GA", 72'(status), 72'h00);
      step(1'b1, 1'b0, 1'b0, 72'h0, 1'b0, '0, '0);
      chk("R11 trap on rise", 72'(trap_req), 72'h1);
      @(negedge clk);
      chk("R11 pulse ends", 72'(trap_req), 72'h0);
      step(1'b1, 1'b0, 1'b0, 72'h0, 1'b0, '0, '0);
      chk("R11 no trap while set", 72'(trap_req), 72'h0);

      // R12 catastrophic trap
      trap_en_ovf_a = 1'b0; trap_en_cat = 1'b1;
      step(1'b1, 1'b0, 1'b0, 72'h1, 1'b0, '0, '0);
      chk("R12 no trap when saturating", 72'(trap_req), 72'h0);
      chk("R12 status", 72'(status), 72'h2B);
      step(1'b0, 1'b0, 1'b0, '0, 1'b1, 6'b001000, 6'b000000);
      chk("R10 clear SA", 72'(status), 72'h22);
      sat_en_a = 1'b0;
      step(1'b1, 1'b0, 1'b0, 72'h1, 1'b0, '0, '0);
      chk("R12 trap unsaturated", 72'(trap_req), 72'h1);
      chk("R6 wrapped value", acc_a, 72'h800000000000000000);
      chk("R6 SA set", 72'(status), 72'h2B);
      chk("R1 B untouched", acc_b, 72'h008000000000000004);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule